// File: doc/BRIEF.md
# Interconnect Performance Monitor

This block watches a multi-port interconnect and counts what happens on it. It holds five 32-bit counters. Counter 0 counts clock cycles. Counters 1 to 4 each count one event, picked from a wide bus of per-port event pulses. Software programs the block through a simple bus that completes a read or a write in a single cycle. It can enable each counter, preload its value, pick its event and clear its overflow flag. One global bit starts and stops all counting at once.

An event identifier is 8 bits wide. The upper three bits name a source port and the lower five bits name an event code on that port. Ports 0 to 4 are on the slave side and ports 5 to 7 are on the master side. The pulse bus is laid out so that the identifier is the bit index itself. Each counter has a sticky overflow flag and its own interrupt line, so an interrupt controller can wire the lines separately or merge them.

Top module: `ixn_perf_mon`

## Requirements
- R1: After reset every count is 0, every counter enable and event select is 0, every overflow flag is 0, all `ovf_irq` lines are low, and the global enable is 0.
- R2: The global control register sits at offset 0x100 of bank 0. Bit 0 is the global enable and can be read and written. Bits 15:11 read as the number of event counters (4), which are read-only. All other bits read as 0.
- R3: A counter advances only while the global enable and its own enable bit are both 1. If either is 0, its count holds.
- R4: Event counter n (n = 1..4) adds one for each cycle in which `evt_pulse[id]` is high, where id is its 8-bit event select. Bits 7:5 of id are the port and bits 4:0 are the code, so the bus bit is port*32+code. Pulses on other bits are not counted.
- R5: Counter 0 adds one on every clock while enabled. Its event select always reads 0, and writes to it are ignored.
- R6: The count register can be written. A write replaces the value and takes priority over an increment in the same cycle. The count wraps from 0xFFFFFFFF to 0.
- R7: The overflow flag sets when an increment takes the count from 0xFFFFFFFF to 0. The flag stays set until 1 is written to bit 0 of the overflow register. Writing 0 there has no effect. If an overflow and a clear happen in the same cycle, the flag stays set.
- R8: `ovf_irq[n]` is high exactly while the overflow flag of counter n is set.
- R9: The identification register at offset 0xFE8 of bank 0 returns the revision (default 5) in bits 7:4 and 0 in all other bits. Writes to it are ignored.
- R10: A read of any unmapped address returns 0, and a write to one changes nothing. This includes banks 5 and above, and offsets other than 0x0/0x4/0x8/0xC/0x100/0xFE8.
- R11: Counter n owns the bank at n*0x1000. Its registers are: event select at offset 0x0 (bits 7:0), count at 0x4, control at 0x8 (bit 0 is the enable), and overflow at 0xC (bit 0 is the flag).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte address: bank in bits 15:12, offset in bits 11:0 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the read |
| evt_pulse | input | 256 | Event pulses; bit index = port*32+code |
| ovf_irq | output | 5 | Per-counter overflow interrupt |

## Verification
The assertions check five properties on every cycle:
- a disabled counter holds its value;
- the cycle counter steps by exactly one while enabled;
- a count write lands on the next cycle;
- a flag never drops without a clear;
- every observed wrap leaves the flag set.

Three behaviours can only be shown by the bench's scenarios:
- the exact number of events counted for a chosen identifier, with neighbouring pulses present;
- priority when a write or a clear meets an increment or an overflow in the same cycle;
- the register map, including the read-only fields and the unmapped holes.

// File: rtl/ipm_pkg.sv
package ipm_pkg;

   // Offsets inside a 4 KB counter bank
   localparam logic [11:0] OFF_SEL  = 12'h000;
   localparam logic [11:0] OFF_CNT  = 12'h004;
   localparam logic [11:0] OFF_CTL  = 12'h008;
   localparam logic [11:0] OFF_OVF  = 12'h00C;
   // Block-wide registers, reachable only in bank 0
   localparam logic [11:0] OFF_GCTL = 12'h100;
   localparam logic [11:0] OFF_ID   = 12'hFE8;

   localparam int NCNT_LSB = 11;
   localparam int NCNT_W   = 5;
   localparam int REV_LSB  = 4;
   localparam int REV_W    = 4;

   typedef enum logic [2:0] {
      RK_NONE,
      RK_SEL,
      RK_CNT,
      RK_CTL,
      RK_OVF,
      RK_GCTL,
      RK_ID
   } reg_kind_e;

   function automatic reg_kind_e classify(input logic [11:0] off, input logic first_bank);
      reg_kind_e k;
      case (off)
         OFF_SEL:  k = RK_SEL;
         OFF_CNT:  k = RK_CNT;
         OFF_CTL:  k = RK_CTL;
         OFF_OVF:  k = RK_OVF;
         OFF_GCTL: k = first_bank ? RK_GCTL : RK_NONE;
         OFF_ID:   k = first_bank ? RK_ID : RK_NONE;
         default:  k = RK_NONE;
      endcase
      return k;
   endfunction

endpackage

// File: rtl/ipm_event_pick.sv
module ipm_event_pick #(
   parameter int ID_W     = 8,
   parameter bit IS_CYCLE = 1'b0
) (
   input  logic [(1<<ID_W)-1:0] pulses,
   input  logic [ID_W-1:0]      sel,
   output logic                 hit
);

   generate
      if (IS_CYCLE) begin : g_cycle
         // the cycle counter sees a hit on every clock
         logic unused_inputs;
         assign unused_inputs = ^{pulses, sel};
         assign hit = 1'b1;
      end else begin : g_event
         assign hit = pulses[sel];
      end
   endgenerate

endmodule

// File: rtl/ipm_counter.sv
module ipm_counter #(
   parameter bit IS_CYCLE = 1'b0,
   parameter int CNT_W    = 32,
   parameter int ID_W     = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 run_en,
   input  logic                 we_sel,
   input  logic                 we_cnt,
   input  logic                 we_ctl,
   input  logic                 we_ovf,
   input  logic [CNT_W-1:0]     wdata,
   input  logic [(1<<ID_W)-1:0] pulses,
   output logic [ID_W-1:0]      sel_q,
   output logic [CNT_W-1:0]     cnt_q,
   output logic                 en_q,
   output logic                 ovf_q
);

   logic hit;
   logic step;
   logic wrap;

   ipm_event_pick #(.ID_W(ID_W), .IS_CYCLE(IS_CYCLE)) u_pick (
      .pulses (pulses),
      .sel    (sel_q),
      .hit    (hit)
   );

   assign step = run_en && en_q && hit;
   assign wrap = step && !we_cnt && (cnt_q == {CNT_W{1'b1}});

   generate
      if (IS_CYCLE) begin : g_no_sel
         logic unused_we_sel;
         assign unused_we_sel = we_sel;
         assign sel_q = '0;
      end else begin : g_sel
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      sel_q <= '0;
            else if (we_sel) sel_q <= wdata[ID_W-1:0];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (we_cnt) cnt_q <= wdata;
      else if (step)   cnt_q <= cnt_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      en_q <= 1'b0;
      else if (we_ctl) en_q <= wdata[0];
   end

   // a new overflow outranks a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  ovf_q <= 1'b0;
      else if (wrap)               ovf_q <= 1'b1;
      else if (we_ovf && wdata[0]) ovf_q <= 1'b0;
   end

   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!(run_en && en_q) && !we_cnt) |=> $stable(cnt_q));

   p_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
      we_cnt |=> (cnt_q == $past(wdata)));

   p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q && !(we_ovf && wdata[0])) |=> ovf_q);

   p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((cnt_q == '0) && ($past(cnt_q) == {CNT_W{1'b1}}) && !$past(we_cnt)) |-> ovf_q);

   generate
      if (IS_CYCLE) begin : g_cyc_chk
         p_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (run_en && en_q && !we_cnt) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
      end
   endgenerate

endmodule

// File: rtl/ixn_perf_mon.sv
module ixn_perf_mon import ipm_pkg::*; #(
   parameter int NUM_EVT_CTRS = 4,
   parameter int CNT_W        = 32,
   parameter int ADDR_W       = 16,
   parameter int SRC_W        = 3,
   parameter int CODE_W       = 5,
   parameter int REVISION     = 5
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              bus_sel,
   input  logic                              bus_wr,
   input  logic [ADDR_W-1:0]                 bus_addr,
   input  logic [CNT_W-1:0]                  bus_wdata,
   output logic [CNT_W-1:0]                  bus_rdata,
   input  logic [(1<<(SRC_W+CODE_W))-1:0]    evt_pulse,
   output logic [NUM_EVT_CTRS:0]             ovf_irq
);

   localparam int NUM_CTRS = NUM_EVT_CTRS + 1;
   localparam int ID_W     = SRC_W + CODE_W;
   localparam int BANK_W   = ADDR_W - 12;

   generate
      if (BANK_W < 1 || NUM_CTRS > (1 << BANK_W)) begin : g_bad_addr
         $error("address too narrow for the counter banks");
      end
      if (NUM_EVT_CTRS >= (1 << NCNT_W)) begin : g_bad_num
         $error("event counter count does not fit its field");
      end
      if (CNT_W < 16 || ID_W > CNT_W) begin : g_bad_width
         $error("counter width too small for the register map");
      end
      if (REVISION >= (1 << REV_W)) begin : g_bad_rev
         $error("revision does not fit its field");
      end
   endgenerate

   logic [11:0]       off;
   logic [BANK_W-1:0] bank;
   reg_kind_e         kind;
   logic              wr_go;
   logic              gen_q;

   assign off   = bus_addr[11:0];
   assign bank  = bus_addr[ADDR_W-1:12];
   assign kind  = classify(off, bank == '0);
   assign wr_go = bus_sel && bus_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           gen_q <= 1'b0;
      else if (wr_go && (kind == RK_GCTL))  gen_q <= bus_wdata[0];
   end

   logic [ID_W-1:0]  sel_v [NUM_CTRS];
   logic [CNT_W-1:0] cnt_v [NUM_CTRS];
   logic             en_v  [NUM_CTRS];
   logic             ovf_v [NUM_CTRS];

   generate
      for (genvar i = 0; i < NUM_CTRS; i++) begin : g_ctr
         logic mine;
         assign mine = wr_go && (bank == BANK_W'(i));

         ipm_counter #(
            .IS_CYCLE (i == 0),
            .CNT_W    (CNT_W),
            .ID_W     (ID_W)
         ) u_ctr (
            .clk    (clk),
            .rst_n  (rst_n),
            .run_en (gen_q),
            .we_sel (mine && (kind == RK_SEL)),
            .we_cnt (mine && (kind == RK_CNT)),
            .we_ctl (mine && (kind == RK_CTL)),
            .we_ovf (mine && (kind == RK_OVF)),
            .wdata  (bus_wdata),
            .pulses (evt_pulse),
            .sel_q  (sel_v[i]),
            .cnt_q  (cnt_v[i]),
            .en_q   (en_v[i]),
            .ovf_q  (ovf_v[i])
         );

         assign ovf_irq[i] = ovf_v[i];
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      if (bus_sel && !bus_wr) begin
         case (kind)
            RK_GCTL: begin
               bus_rdata[0] = gen_q;
               bus_rdata[NCNT_LSB +: NCNT_W] = NCNT_W'(NUM_EVT_CTRS);
            end
            RK_ID: bus_rdata[REV_LSB +: REV_W] = REV_W'(REVISION);
            default: begin
               for (int i = 0; i < NUM_CTRS; i++) begin
                  if (bank == BANK_W'(i)) begin
                     case (kind)
                        RK_SEL:  bus_rdata[ID_W-1:0] = sel_v[i];
                        RK_CNT:  bus_rdata = cnt_v[i];
                        RK_CTL:  bus_rdata[0] = en_v[i];
                        RK_OVF:  bus_rdata[0] = ovf_v[i];
                        default: bus_rdata = '0;
                     endcase
                  end
               end
            end
         endcase
      end
   end

endmodule

// File: tb/sim_ixn_perf_mon.sv
module sim_ixn_perf_mon;

   localparam int CLK_PERIOD = 10;

   typedef struct packed {
      logic        wr;
      logic [15:0] addr;
      logic [31:0] data;
   } vec_t;

   // writes apply data; reads compare against data. Global enable stays 0.
   localparam int NV = 17;
   localparam vec_t TBL [NV] = '{
      '{1'b0, 16'h0100, 32'h0000_2000},  // R2 count field 4 at bits 15:11
      '{1'b0, 16'h0FE8, 32'h0000_0050},  // R9 revision 5 at bits 7:4
      '{1'b1, 16'h1004, 32'h1234_5678},  // R11 bank 1 count
      '{1'b0, 16'h1004, 32'h1234_5678},  // R6 readback
      '{1'b1, 16'h2000, 32'hFFFF_FFC3},  // R11 select keeps 8 bits
      '{1'b0, 16'h2000, 32'h0000_00C3},  // R4
      '{1'b1, 16'h0000, 32'h0000_00AB},  // R5 cycle select ignored
      '{1'b0, 16'h0000, 32'h0000_0000},  // R5
      '{1'b1, 16'h5004, 32'h0000_DEAD},  // R10 bank 5 unmapped
      '{1'b0, 16'h5004, 32'h0000_0000},  // R10
      '{1'b0, 16'h1004, 32'h1234_5678},  // R10 no alias into bank 1
      '{1'b1, 16'h1010, 32'hFFFF_FFFF},  // R10 unmapped offset
      '{1'b0, 16'h1010, 32'h0000_0000},  // R10
      '{1'b1, 16'h0FE8, 32'h0000_0000},  // R9 read-only
      '{1'b0, 16'h0FE8, 32'h0000_0050},  // R9
      '{1'b1, 16'h4008, 32'hFFFF_FFFF},  // R11 control keeps bit 0
      '{1'b0, 16'h4008, 32'h0000_0001}   // R11
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         bus_sel = 1'b0;
   logic         bus_wr = 1'b0;
   logic [15:0]  bus_addr = '0;
   logic [31:0]  bus_wdata = '0;
   logic [31:0]  bus_rdata;
   logic [255:0] evt_pulse = '0;
   logic [4:0]   ovf_irq;

   int n_chk = 0;
   int n_err = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ixn_perf_mon u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .evt_pulse (evt_pulse),
      .ovf_irq   (ovf_irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [15:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [15:0] a, input logic [31:0] exp);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1;
      check(req, bus_rdata, exp);
      bus_sel = 1'b0;
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd_chk("R1", 16'h0004, 32'h0);
      rd_chk("R1", 16'h1004, 32'h0);
      rd_chk("R1", 16'h3008, 32'h0);
      rd_chk("R1", 16'h200C, 32'h0);
      check("R1", {27'd0, ovf_irq}, 32'h0);

      // register-map table
      for (int i = 0; i < NV; i++) begin
         if (TBL[i].wr) wr(TBL[i].addr, TBL[i].data);
         else rd_chk("table", TBL[i].addr, TBL[i].data);
      end

      // R5 cycle counter: enable at edge E, disable captured at E+7
      wr(16'h0004, 32'h0);
      wr(16'h0008, 32'h1);
      wr(16'h0100, 32'h1);
      rd_chk("R2", 16'h0100, 32'h0000_2001);
      repeat (4) @(negedge clk);
      wr(16'h0100, 32'h0);
      rd_chk("R5", 16'h0004, 32'd7);
      repeat (3) @(negedge clk);
      rd_chk("R3", 16'h0004, 32'd7);  // R3 global off holds
      wr(16'h0008, 32'h0);

      // R4 event selection: counter1 id 0xC3 (port 6 code 3), counter2 id 0x03,
      // counter3 id 0xC3 but disabled (R3)
      wr(16'h1004, 32'h0); wr(16'h1000, 32'hC3); wr(16'h1008, 32'h1);
      wr(16'h2004, 32'h0); wr(16'h2000, 32'h03); wr(16'h2008, 32'h1);
      wr(16'h3004, 32'h0); wr(16'h3000, 32'hC3); wr(16'h3008, 32'h0);
      wr(16'h4004, 32'h0); wr(16'h4000, 32'h20); wr(16'h4008, 32'h1);
      wr(16'h0100, 32'h1);
      evt_pulse[195] = 1'b1;
      repeat (4) @(negedge clk);
      evt_pulse[195] = 1'b0;
      evt_pulse[3] = 1'b1;
      repeat (2) @(negedge clk);
      evt_pulse[3] = 1'b0;
      wr(16'h0100, 32'h0);
      rd_chk("R4", 16'h1004, 32'd4);
      rd_chk("R4", 16'h2004, 32'd2);
      rd_chk("R3", 16'h3004, 32'd0);
      rd_chk("R4", 16'h4004, 32'd0);
      // R3 pulses with global off are not counted
      evt_pulse[3] = 1'b1;
      repeat (3) @(negedge clk);
      evt_pulse[3] = 1'b0;
      rd_chk("R3", 16'h2004, 32'd2);

      // R6 write beats increment: increments E+1, load 100 at E+2, increments E+3, E+4
      wr(16'h1008, 32'h0); wr(16'h2008, 32'h0); wr(16'h4008, 32'h0);
      wr(16'h0008, 32'h1);
      wr(16'h0100, 32'h1);
      wr(16'h0004, 32'd100);
      wr(16'h0100, 32'h0);
      rd_chk("R6", 16'h0004, 32'd102);

      // R7 overflow on wrap: FFFFFFFE -> FFFFFFFF -> 0
      wr(16'h0004, 32'hFFFF_FFFE);
      wr(16'h0100, 32'h1);
      wr(16'h0100, 32'h0);
      rd_chk("R6", 16'h0004, 32'h0);
      rd_chk("R7", 16'h000C, 32'h1);
      check("R8", {27'd0, ovf_irq}, 32'h1);
      wr(16'h000C, 32'h0);
      rd_chk("R7", 16'h000C, 32'h1);

      // R7 set wins: overflow at E+2 meets the clear at E+2
      wr(16'h0004, 32'hFFFF_FFFE);
      wr(16'h0100, 32'h1);
      wr(16'h000C, 32'h1);
      wr(16'h0100, 32'h0);
      rd_chk("R7", 16'h000C, 32'h1);
      rd_chk("R6", 16'h0004, 32'd2);
      wr(16'h000C, 32'h1);
      rd_chk("R7", 16'h000C, 32'h0);
      check("R8", {27'd0, ovf_irq}, 32'h0);
      wr(16'h0008, 32'h0);

      // R8 event counter 2 overflow drives line 2 only
      wr(16'h2004, 32'hFFFF_FFFF); wr(16'h2000, 32'h03); wr(16'h2008, 32'h1);
      wr(16'h0100, 32'h1);
      evt_pulse[3] = 1'b1;
      @(negedge clk);
      evt_pulse[3] = 1'b0;
      wr(16'h0100, 32'h0);
      rd_chk("R6", 16'h2004, 32'h0);
      rd_chk("R7", 16'h200C, 32'h1);
      check("R8", {27'd0, ovf_irq}, 32'h4);
      wr(16'h200C, 32'h1);
      check("R8", {27'd0, ovf_irq}, 32'h0);

      finish_run();
   end

endmodule